// File: doc/BRIEF.md
# Rotate-Right-Through-Carry Execution Unit

This unit executes the rotate-right-through-carry instruction of a CPU whose accumulator can run eight or sixteen bits wide. A command carries the opcode, the width mode, the low byte of the direct-page register, the incoming carry, the accumulator and an effective address that has already been computed. The accumulator form rotates the register in place. The four memory forms fetch the operand over a byte-wide memory port, rotate it and write it back. Each instruction ends with new carry, negative and zero flags, plus the instruction length in bytes and its cycle count.

Commands enter over a valid/ready handshake. `cmd_ready` is high only while the unit is idle, so a command stays on the port until the unit can take it. The memory port is also valid/ready. The unit holds address, direction and write data steady until the memory side raises `mem_ready`. Read data is taken in the same cycle as that handshake. Completion is a one-cycle `done` pulse. A command with an opcode the unit does not recognise produces a one-cycle `bad_opcode` pulse instead.

Top module: `ror_unit`

## Requirements
- R1: The opcodes 0x6A (accumulator), 0x6E (absolute), 0x66 (direct page), 0x7E (absolute, X indexed) and 0x76 (direct page, X indexed) are executed. Each produces `done` one or more cycles after it is accepted.
- R2: The result is the operand shifted right by one. The incoming carry enters bit 7 in 8-bit mode (`cmd_wide`=0) or bit 15 in 16-bit mode (`cmd_wide`=1). Operand bit 0 becomes `carry_out`.
- R3: In 8-bit mode the accumulator form replaces only `acc_out[7:0]`; `acc_out[15:8]` keeps the incoming upper byte. Memory forms return the incoming accumulator unchanged on `acc_out`.
- R4: `neg_out` is the top bit of the result at the active width. `zero_out` is 1 exactly when the result bits at the active width are all zero.
- R5: `len_out` is 1 for the accumulator form, 3 for both absolute forms and 2 for both direct-page forms.
- R6: `cyc_out` is 2 for the accumulator form. It is 6/8 for absolute and 7/9 for absolute X indexed (8-bit/16-bit), with no page-crossing adjustment.
- R7: `cyc_out` is 5/7 for direct page and 6/8 for direct page X indexed (8-bit/16-bit). Each of these gets one more cycle when `cmd_dp_low` is nonzero.
- R8: Any other opcode gives a one-cycle `bad_opcode` pulse with no `done`. It leaves the accumulator, flags, length and cycle outputs unchanged and makes no memory access.
- R9: A memory form first reads the low byte at the effective address. In 16-bit mode it then reads the high byte at the address plus one, wrapping at the top of the address space. It writes back low byte then high byte to the same addresses. Each request is held stable until `mem_ready`.
- R10: `done` lasts one cycle. The result outputs keep their values after it until the next completion.
- R11: `cmd_ready` is low from the acceptance of a memory-form command until its completion, so no command is accepted while memory traffic is outstanding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Unit idle and taking a command |
| cmd_opcode | input | 8 | Instruction opcode |
| cmd_wide | input | 1 | 1 = 16-bit width, 0 = 8-bit width |
| cmd_dp_low | input | 8 | Low byte of the direct-page register |
| cmd_carry | input | 1 | Carry flag before the instruction |
| cmd_acc | input | 16 | Accumulator before the instruction |
| cmd_ea | input | AW | Effective address of the memory operand |
| mem_valid | output | 1 | Memory request present |
| mem_ready | input | 1 | Memory request taken this cycle |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | AW | Byte address |
| mem_wdata | output | 8 | Write byte |
| mem_rdata | input | 8 | Read byte, valid with mem_ready on a read |
| done | output | 1 | One-cycle completion pulse |
| bad_opcode | output | 1 | One-cycle unknown-opcode pulse |
| acc_out | output | 16 | Accumulator after the instruction |
| carry_out | output | 1 | Carry after the instruction |
| neg_out | output | 1 | Negative flag after the instruction |
| zero_out | output | 1 | Zero flag after the instruction |
| len_out | output | 2 | Instruction length in bytes |
| cyc_out | output | CYC_W | Instruction cycle count |

## Verification
The bench builds the unit with its defaults: a 24-bit address (AW=24) and a 4-bit cycle field (CYC_W=4), which holds the largest count of 9. The full 24-bit address lets a 16-bit operand sit at 0xFFFFFF, so the high byte has to come from 0x000000. The bench also applies random memory stalls, which exercise the hold rules on the memory port while the command side is held off.

// File: rtl/ror_pkg.sv
package ror_pkg;

  typedef enum logic [2:0] {
    FORM_ACC,
    FORM_ABS,
    FORM_DIR,
    FORM_ABSX,
    FORM_DIRX,
    FORM_NONE
  } form_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD_LO,
    ST_RD_HI,
    ST_WR_LO,
    ST_WR_HI
  } state_e;

  localparam logic [7:0] OPC_ACC  = 8'h6A;
  localparam logic [7:0] OPC_ABS  = 8'h6E;
  localparam logic [7:0] OPC_DIR  = 8'h66;
  localparam logic [7:0] OPC_ABSX = 8'h7E;
  localparam logic [7:0] OPC_DIRX = 8'h76;

endpackage

// File: rtl/ror_decode.sv
module ror_decode
  import ror_pkg::*;
#(
  parameter int CYC_W = 4
) (
  input  logic [7:0]       opcode,
  input  logic             wide,
  input  logic             dp_misaligned,
  output form_e            form,
  output logic [1:0]       len,
  output logic [CYC_W-1:0] cycles
);

  localparam logic [CYC_W-1:0] WIDE_EXTRA = CYC_W'(2);

  logic [CYC_W-1:0] base;
  logic             has_dp;

  always_comb begin
    form   = FORM_NONE;
    len    = 2'd0;
    base   = '0;
    has_dp = 1'b0;
    unique case (opcode)
      OPC_ACC:  begin form = FORM_ACC;  len = 2'd1; base = CYC_W'(2); end
      OPC_ABS:  begin form = FORM_ABS;  len = 2'd3; base = CYC_W'(6); end
      OPC_DIR:  begin form = FORM_DIR;  len = 2'd2; base = CYC_W'(5); has_dp = 1'b1; end
      OPC_ABSX: begin form = FORM_ABSX; len = 2'd3; base = CYC_W'(7); end
      OPC_DIRX: begin form = FORM_DIRX; len = 2'd2; base = CYC_W'(6); has_dp = 1'b1; end
      default:  ;
    endcase
  end

  always_comb begin
    cycles = base;
    if (wide && form != FORM_ACC && form != FORM_NONE) cycles = cycles + WIDE_EXTRA;
    if (has_dp && dp_misaligned) cycles = cycles + CYC_W'(1);
  end

endmodule

// File: rtl/ror_rotate.sv
module ror_rotate (
  input  logic [15:0] operand,
  input  logic        wide,
  input  logic        carry_in,
  output logic [15:0] result,
  output logic        carry_out,
  output logic        negative,
  output logic        zero
);

  always_comb begin
    if (wide) begin
      result   = {carry_in, operand[15:1]};
      negative = result[15];
      zero     = (result == 16'h0000);
    end else begin
      result   = {operand[15:8], carry_in, operand[7:1]};
      negative = result[7];
      zero     = (result[7:0] == 8'h00);
    end
    carry_out = operand[0];
  end

endmodule

// File: rtl/ror_unit.sv
module ror_unit
  import ror_pkg::*;
#(
  parameter int AW    = 24,
  parameter int CYC_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  output logic             cmd_ready,
  input  logic [7:0]       cmd_opcode,
  input  logic             cmd_wide,
  input  logic [7:0]       cmd_dp_low,
  input  logic             cmd_carry,
  input  logic [15:0]      cmd_acc,
  input  logic [AW-1:0]    cmd_ea,
  output logic             mem_valid,
  input  logic             mem_ready,
  output logic             mem_we,
  output logic [AW-1:0]    mem_addr,
  output logic [7:0]       mem_wdata,
  input  logic [7:0]       mem_rdata,
  output logic             done,
  output logic             bad_opcode,
  output logic [15:0]      acc_out,
  output logic             carry_out,
  output logic             neg_out,
  output logic             zero_out,
  output logic [1:0]       len_out,
  output logic [CYC_W-1:0] cyc_out
);

  localparam logic [AW-1:0] NEXT_BYTE = AW'(1);

  state_e           state_q;
  logic             wide_q, cin_q;
  logic [AW-1:0]    ea_q;
  logic [15:0]      opnd_q;
  logic [1:0]       len_q;
  logic [CYC_W-1:0] cyc_q;

  form_e            dec_form;
  logic [1:0]       dec_len;
  logic [CYC_W-1:0] dec_cyc;

  logic [15:0]      rot_in, rot_res;
  logic             rot_wide, rot_cin, rot_c, rot_n, rot_z;

  logic             accept, hs, is_idle;

  ror_decode #(.CYC_W(CYC_W)) u_decode (
    .opcode        (cmd_opcode),
    .wide          (cmd_wide),
    .dp_misaligned (|cmd_dp_low),
    .form          (dec_form),
    .len           (dec_len),
    .cycles        (dec_cyc)
  );

  assign is_idle  = (state_q == ST_IDLE);
  assign rot_in   = is_idle ? cmd_acc   : opnd_q;
  assign rot_wide = is_idle ? cmd_wide  : wide_q;
  assign rot_cin  = is_idle ? cmd_carry : cin_q;

  ror_rotate u_rotate (
    .operand   (rot_in),
    .wide      (rot_wide),
    .carry_in  (rot_cin),
    .result    (rot_res),
    .carry_out (rot_c),
    .negative  (rot_n),
    .zero      (rot_z)
  );

  assign cmd_ready = is_idle;
  assign accept    = cmd_valid && cmd_ready;
  assign mem_valid = !is_idle;
  assign mem_we    = (state_q == ST_WR_LO) || (state_q == ST_WR_HI);
  assign mem_addr  = ((state_q == ST_RD_HI) || (state_q == ST_WR_HI)) ? ea_q + NEXT_BYTE : ea_q;
  assign mem_wdata = (state_q == ST_WR_HI) ? rot_res[15:8] : rot_res[7:0];
  assign hs        = mem_valid && mem_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      wide_q     <= 1'b0;
      cin_q      <= 1'b0;
      ea_q       <= '0;
      opnd_q     <= '0;
      len_q      <= '0;
      cyc_q      <= '0;
      done       <= 1'b0;
      bad_opcode <= 1'b0;
      acc_out    <= '0;
      carry_out  <= 1'b0;
      neg_out    <= 1'b0;
      zero_out   <= 1'b0;
      len_out    <= '0;
      cyc_out    <= '0;
    end else begin
      done       <= 1'b0;
      bad_opcode <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (accept) begin
          if (dec_form == FORM_NONE) begin
            bad_opcode <= 1'b1;
          end else if (dec_form == FORM_ACC) begin
            acc_out   <= rot_res;
            carry_out <= rot_c;
            neg_out   <= rot_n;
            zero_out  <= rot_z;
            len_out   <= dec_len;
            cyc_out   <= dec_cyc;
            done      <= 1'b1;
          end else begin
            wide_q  <= cmd_wide;
            cin_q   <= cmd_carry;
            ea_q    <= cmd_ea;
            opnd_q  <= '0;
            len_q   <= dec_len;
            cyc_q   <= dec_cyc;
            acc_out <= cmd_acc;
            state_q <= ST_RD_LO;
          end
        end
        ST_RD_LO: if (hs) begin
          opnd_q[7:0] <= mem_rdata;
          state_q     <= wide_q ? ST_RD_HI : ST_WR_LO;
        end
        ST_RD_HI: if (hs) begin
          opnd_q[15:8] <= mem_rdata;
          state_q      <= ST_WR_LO;
        end
        ST_WR_LO, ST_WR_HI: if (hs) begin
          if (state_q == ST_WR_LO && wide_q) begin
            state_q <= ST_WR_HI;
          end else begin
            carry_out <= rot_c;
            neg_out   <= rot_n;
            zero_out  <= rot_z;
            len_out   <= len_q;
            cyc_out   <= cyc_q;
            done      <= 1'b1;
            state_q   <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // R9: a stalled memory request keeps every field steady
  p_req_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && !mem_ready |=> mem_valid && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata));

  // R9: a write never directly follows acceptance
  p_read_first_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_valid) |-> !mem_we);

  // R10: completion is a single-cycle pulse
  p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R11: command side closed while memory traffic is pending
  p_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid |-> !cmd_ready);

  // R8: unknown opcode leaves results untouched and does not complete
  p_bad_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    bad_opcode |-> !done && !mem_valid && $stable(acc_out) && $stable(carry_out) && $stable(cyc_out));

  // R4: a zero result cannot be negative
  p_flag_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !(zero_out && neg_out));

  // R5: every completion reports a nonzero length
  p_len_nonzero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> len_out != 2'd0);

endmodule

// File: tb/test_ror_unit.sv
module test_ror_unit;

  localparam int AW = 24;
  localparam int CW = 4;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          cmd_valid, cmd_ready, cmd_wide, cmd_carry;
  logic [7:0]    cmd_opcode, cmd_dp_low;
  logic [15:0]   cmd_acc;
  logic [AW-1:0] cmd_ea;
  logic          mem_valid, mem_ready, mem_we;
  logic [AW-1:0] mem_addr;
  logic [7:0]    mem_wdata, mem_rdata;
  logic          done, bad_opcode, carry_out, neg_out, zero_out;
  logic [15:0]   acc_out;
  logic [1:0]    len_out;
  logic [CW-1:0] cyc_out;

  always #10 clk = ~clk;

  ror_unit #(.AW(AW), .CYC_W(CW)) i_ror_unit (.*);

  typedef struct {
    logic        err;
    logic [15:0] acc;
    logic        c, n, z;
    logic [1:0]  len;
    logic [3:0]  cyc;
  } res_t;

  typedef struct {
    logic          we;
    logic [AW-1:0] addr;
    logic [7:0]    data;
  } beat_t;

  res_t  res_q[$];
  beat_t beat_q[$];
  res_t  last;
  logic [7:0] mem [bit [AW-1:0]];
  int checks = 0;
  int errors = 0;
  int stall  = 0;

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  // memory responder with random stalls; checks each beat against expectation (R9)
  initial begin
    mem_ready = 1'b0;
    mem_rdata = 8'h00;
    forever begin
      @(negedge clk);
      if (mem_valid && stall == 0) begin
        beat_t b;
        if (beat_q.size() == 0) begin
          check("R8", "unexpected memory beat", 32'(mem_addr), 32'hFFFF_FFFF);
        end else begin
          b = beat_q.pop_front();
          check("R9", "beat direction", 32'(mem_we), 32'(b.we));
          check("R9", "beat address", 32'(mem_addr), 32'(b.addr));
          if (b.we) begin
            check("R2", "write byte", 32'(mem_wdata), 32'(b.data));
            mem[mem_addr] = mem_wdata;
          end else begin
            mem_rdata = mem[mem_addr];
          end
        end
        mem_ready = 1'b1;
        stall = int'($urandom % 3);
      end else begin
        mem_ready = 1'b0;
        if (mem_valid && stall > 0) stall--;
      end
    end
  end

  // monitor: pops expected results on done / bad_opcode
  initial begin
    forever begin
      @(negedge clk);
      if (done || bad_opcode) begin
        res_t e;
        if (res_q.size() == 0) begin
          check("R1", "unexpected completion", 32'(done), 32'd0);
        end else begin
          e = res_q.pop_front();
          check(e.err ? "R8" : "R1", "bad_opcode", 32'(bad_opcode), 32'(e.err));
          check(e.err ? "R8" : "R1", "done", 32'(done), 32'(!e.err));
          check(e.err ? "R8" : "R3", "acc_out", 32'(acc_out), 32'(e.acc));
          check(e.err ? "R8" : "R2", "carry_out", 32'(carry_out), 32'(e.c));
          check(e.err ? "R8" : "R4", "neg_out", 32'(neg_out), 32'(e.n));
          check(e.err ? "R8" : "R4", "zero_out", 32'(zero_out), 32'(e.z));
          check(e.err ? "R8" : "R5", "len_out", 32'(len_out), 32'(e.len));
          check(e.err ? "R8" : "R6", "cyc_out", 32'(cyc_out), 32'(e.cyc));
        end
      end
    end
  end

  task automatic run(input logic [7:0] op, input logic wide, input logic [7:0] dpl,
                     input logic c, input logic [15:0] acc, input logic [AW-1:0] ea,
                     input logic [15:0] mval);
    res_t          e;
    logic [15:0]   opnd, r;
    logic [AW-1:0] ea1;
    logic          is_mem, known;
    int            base;
    ea1    = ea + AW'(1);
    known  = 1'b1;
    is_mem = 1'b1;
    base   = 0;
    e.len  = 2'd0;
    case (op)
      8'h6A: begin is_mem = 1'b0; e.len = 2'd1; base = 2; end
      8'h6E: begin e.len = 2'd3; base = wide ? 8 : 6; end
      8'h7E: begin e.len = 2'd3; base = wide ? 9 : 7; end
      8'h66: begin e.len = 2'd2; base = (wide ? 7 : 5) + (dpl != 0 ? 1 : 0); end
      8'h76: begin e.len = 2'd2; base = (wide ? 8 : 6) + (dpl != 0 ? 1 : 0); end
      default: known = 1'b0;
    endcase
    e.cyc = 4'(base);
    opnd  = is_mem ? (wide ? mval : {8'h00, mval[7:0]}) : acc;
    r     = wide ? {c, opnd[15:1]} : {opnd[15:8], c, opnd[7:1]};
    e.err = 1'b0;
    e.c   = opnd[0];
    e.n   = wide ? r[15] : r[7];
    e.z   = wide ? (r == 16'h0) : (r[7:0] == 8'h0);
    e.acc = is_mem ? acc : r;
    if (!known) begin
      e = last;
      e.err = 1'b1;
    end else begin
      last = e;
      if (is_mem) begin
        mem[ea] = mval[7:0];
        if (wide) mem[ea1] = mval[15:8];
        beat_q.push_back('{1'b0, ea, 8'h00});
        if (wide) beat_q.push_back('{1'b0, ea1, 8'h00});
        beat_q.push_back('{1'b1, ea, r[7:0]});
        if (wide) beat_q.push_back('{1'b1, ea1, r[15:8]});
      end
    end
    res_q.push_back(e);
    @(negedge clk);
    while (!cmd_ready) @(negedge clk);
    cmd_opcode = op; cmd_wide = wide; cmd_dp_low = dpl;
    cmd_carry = c; cmd_acc = acc; cmd_ea = ea; cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    if (known && is_mem) check("R11", "cmd_ready while busy", 32'(cmd_ready), 32'd0);
    while (res_q.size() != 0) @(negedge clk);
    if (is_mem) check("R9", "all beats consumed", 32'(beat_q.size()), 32'd0);
  endtask

  initial begin
    rst_n = 1'b0;
    cmd_valid = 1'b0; cmd_opcode = 8'h00; cmd_wide = 1'b0; cmd_dp_low = 8'h00;
    cmd_carry = 1'b0; cmd_acc = 16'h0; cmd_ea = '0;
    last = '{1'b0, 16'h0, 1'b0, 1'b0, 1'b0, 2'd0, 4'd0};
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R11", "reset cmd_ready", 32'(cmd_ready), 32'd1);
    check("R10", "reset done", 32'(done), 32'd0);
    check("R9", "reset mem_valid", 32'(mem_valid), 32'd0);
    check("R8", "reset bad_opcode", 32'(bad_opcode), 32'd0);

    // accumulator form, 8-bit: upper byte kept (R3), carry into bit 7 (R2)
    run(8'h6A, 1'b0, 8'h00, 1'b0, 16'h1281, '0, 16'h0);
    run(8'h6A, 1'b0, 8'h00, 1'b1, 16'hAB01, '0, 16'h0);
    // 8-bit zero with nonzero upper byte (R4)
    run(8'h6A, 1'b0, 8'h00, 1'b0, 16'hFF01, '0, 16'h0);
    // 16-bit accumulator (R2, R4)
    run(8'h6A, 1'b1, 8'h00, 1'b1, 16'h0002, '0, 16'h0);
    run(8'h6A, 1'b1, 8'h00, 1'b0, 16'h0001, '0, 16'h0);
    // R10: outputs held after done
    repeat (3) @(negedge clk);
    check("R10", "acc_out held", 32'(acc_out), 32'(last.acc));
    check("R10", "zero_out held", 32'(zero_out), 32'(last.z));
    // unknown opcode (R8)
    run(8'h6B, 1'b1, 8'h00, 1'b1, 16'h5555, 24'h000100, 16'h0);
    // absolute (R6)
    run(8'h6E, 1'b0, 8'h00, 1'b1, 16'h3344, 24'h001234, 16'h0003);
    run(8'h6E, 1'b1, 8'h00, 1'b0, 16'h3344, 24'h002000, 16'h0100);
    // direct page with and without penalty (R7)
    run(8'h66, 1'b0, 8'h00, 1'b0, 16'h0000, 24'h000010, 16'h0080);
    run(8'h66, 1'b1, 8'h10, 1'b1, 16'h0000, 24'h000020, 16'hFFFF);
    run(8'h66, 1'b1, 8'h00, 1'b0, 16'h0000, 24'h000030, 16'h0001);
    // absolute indexed (R6)
    run(8'h7E, 1'b0, 8'hFF, 1'b0, 16'h7777, 24'h7F0000, 16'h00FE);
    run(8'h7E, 1'b1, 8'h00, 1'b1, 16'h7777, 24'h7F0100, 16'h8000);
    // direct page indexed (R7)
    run(8'h76, 1'b0, 8'hFF, 1'b1, 16'h0000, 24'h0000FF, 16'h0001);
    run(8'h76, 1'b1, 8'h00, 1'b0, 16'h0000, 24'h000040, 16'h1234);
    // address wrap on high byte (R9)
    run(8'h6E, 1'b1, 8'h00, 1'b1, 16'h0000, 24'hFFFFFF, 16'hA5C3);
    check("R9", "wrapped high byte written", 32'(mem[24'h000000]), 32'h00D2);
    // second unknown opcode after a memory form (R8)
    run(8'h00, 1'b0, 8'h00, 1'b0, 16'h9999, 24'h000050, 16'h0);
    repeat (4) @(negedge clk);
    check("R8", "no stray beats", 32'(beat_q.size()), 32'd0);
    finish_run();
  end

endmodule